// File: doc/BRIEF.md
# Programmable Line-Length Clock Divider

This block counts cycles of a pixel-rate clock and raises a single-cycle pulse once per video line. The pulse marks the end of each line and is the divided clock that an outer loop would phase-compare with the horizontal sync. The number of clocks in a line is set by a 12-bit value that software stores in two byte-wide registers. The hardware adds a fixed 8 clocks to that value.

Software reaches the registers through a plain byte-addressed port: address, write strobe, write data and combinational read data. The low byte of the value lives at address 0x02. The upper four bits live in the low nibble of address 0x03, and the top nibble there is reserved.

The counter does not read the registers while a line is running. At each line boundary it takes a shadow copy of both registers at once. A write made in the middle of a line therefore changes only the following line, and a line never sees half of an update.

Top module: `line_div`

## Requirements
- R1: While reset is held, the low byte resets to 0xFF, the high nibble to 0x0, the counter to 0 and `line_pulse` is low. The first pulse appears 262 clocks after reset is released, one full 263-clock line counted from count 0.
- R2: Address 0x02 holds bits 7..0 of the programmed value. A write there is visible on `reg_rdata` from the following cycle.
- R3: Bits 3..0 of address 0x03 hold bits 11..8 of the value. Bits 7..4 of that address always read as 0, and writing ones or zeros to them is accepted with no effect.
- R4: Successive line pulses are exactly (programmed value + 8) clocks apart.
- R5: Odd programmed values give odd line lengths with no rounding (value 13 gives 21 clocks, value 1 gives 9).
- R6: The value is {address 0x03 bits 3..0, address 0x02 bits 7..0}. For example, 0x01 and 0x00 give 256, so the line is 264 clocks.
- R7: A write during a line leaves that line's length unchanged. The new low byte and high nibble take effect together from the next line, even when they are written in separate cycles.
- R8: `line_pulse` is high for exactly one clock, on the last count of each line.
- R9: Reads from any address other than 0x02 or 0x03 return 0. Writes to such addresses change neither register nor the line length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| line_pulse | output | 1 | One-clock end-of-line pulse |

## Verification
Read data follows the address within the same cycle. The bench therefore sets an address just after one falling edge and compares `reg_rdata` at the next falling edge, and a write is checked on a read issued in the cycle after its strobe.

Line lengths are checked only at pulses. The monitor measures the falling-edge distance between consecutive pulses and compares it with the length queued by the driver. The driver queues each line's length when that line begins, using the value that was active at its start. A write made in one line is expected to show up only in the length of the line after it.

// File: rtl/line_div.sv
module line_div #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int MOD_W    = 12,
  parameter int OFFSET   = 8,
  parameter int LO_ADDR  = 2,
  parameter int HI_ADDR  = 3,
  parameter int LO_RESET = 255,
  parameter int HI_RESET = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          line_pulse
);
  localparam int HI_W     = MOD_W - DW;
  localparam int CNT_W    = $clog2((1 << MOD_W) + OFFSET);
  localparam int RST_TERM = HI_RESET * (1 << DW) + LO_RESET + OFFSET - 1;

  logic [DW-1:0]    lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [CNT_W-1:0] cnt_q, term_q, term_d;
  logic             sel_lo, sel_hi;

  assign sel_lo = (reg_addr == AW'(LO_ADDR));
  assign sel_hi = (reg_addr == AW'(HI_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= DW'(LO_RESET);
      hi_q <= HI_W'(HI_RESET);
    end else if (reg_we) begin
      if (sel_lo) lo_q <= reg_wdata;
      if (sel_hi) hi_q <= reg_wdata[HI_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_lo) reg_rdata = lo_q;
    else if (sel_hi) reg_rdata = {{(DW-HI_W){1'b0}}, hi_q};
  end

  assign term_d     = CNT_W'({hi_q, lo_q}) + CNT_W'(OFFSET - 1);
  assign line_pulse = (cnt_q == term_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      term_q <= CNT_W'(RST_TERM);
    end else if (line_pulse) begin
      cnt_q  <= '0;
      term_q <= term_d;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

module line_div_chk #(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int CNT_W   = 13,
  parameter int LO_ADDR = 2,
  parameter int HI_ADDR = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    reg_addr,
  input logic             reg_we,
  input logic [DW-1:0]    reg_wdata,
  input logic [DW-1:0]    reg_rdata,
  input logic             line_pulse,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] term_q
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |=> !line_pulse); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != AW'(LO_ADDR) && reg_addr != AW'(HI_ADDR)) |-> reg_rdata == '0); // R9
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(HI_ADDR)) |-> reg_rdata[DW-1:4] == '0); // R3
  AST_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(LO_ADDR)) |=>
      (reg_addr != AW'(LO_ADDR) || reg_rdata == $past(reg_wdata))); // R2
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_pulse |=> $stable(term_q)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term_q); // R4
endmodule

bind line_div line_div_chk #(
  .AW(AW), .DW(DW), .CNT_W(CNT_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_pulse(line_pulse),
  .cnt_q(cnt_q), .term_q(term_q)
);

// File: tb/sim_line_div.sv
module sim_line_div;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0, reg_we = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       line_pulse;

  int checks = 0, errors = 0;
  int cyc = 0, last = 0;
  logic prev_pulse = 0;
  int act;
  bit done = 0;

  int    len_q[$];
  string len_tag[$];
  int    rd_q[$];
  string rd_tag[$];
  event  pulse_ev;

  line_div u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
               .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_pulse(line_pulse));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic push_len(int n, string tag);
    len_q.push_back(n);
    len_tag.push_back(tag);
  endtask

  task automatic wr(int a, int d);
    reg_addr = 8'(a); reg_wdata = 8'(d); reg_we = 1;
    @(negedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(int a, int e, string tag);
    reg_addr = 8'(a);
    rd_q.push_back(e);
    rd_tag.push_back(tag);
    @(negedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (rd_q.size() > 0) begin
      int e;
      string t;
      e = rd_q.pop_front();
      t = rd_tag.pop_front();
      check(reg_rdata == 8'(e), t, reg_rdata, e);
    end
    if (rst_n) begin
      cyc++;
      if (prev_pulse) check(!line_pulse, "R8", line_pulse, 0);
      prev_pulse = line_pulse;
      if (line_pulse) begin
        if (len_q.size() > 0) begin
          int e;
          string t;
          e = len_q.pop_front();
          t = len_tag.pop_front();
          check(cyc - last == e, t, cyc - last, e);
        end else begin
          check(0, "R4 unexpected pulse", cyc - last, 0);
        end
        last = cyc;
        -> pulse_ev;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(line_pulse == 0, "R1 pulse in reset", line_pulse, 0);
    @(negedge clk); #1;
    rst_n = 1;
    push_len(262, "R1 first pulse");
    rd(2, 8'hFF, "R1 low reset");
    rd(3, 8'h00, "R1 high reset");
    rd(7, 8'h00, "R9 unmapped read");
    act = 255;

    @(pulse_ev); #1;
    push_len(act + 8, "R7 line unchanged by write");
    wr(2, 8'h10);
    wr(3, 8'hA0);
    rd(3, 8'h00, "R3 reserved read zero");
    rd(2, 8'h10, "R2 low readback");
    act = 16;

    @(pulse_ev); #1;
    push_len(act + 8, "R4 even length");
    wr(2, 8'h0D);
    act = 13;

    @(pulse_ev); #1;
    push_len(act + 8, "R5 odd length");
    wr(4, 8'h55);
    wr(8'h83, 8'h77);
    rd(2, 8'h0D, "R9 low untouched");
    rd(3, 8'h00, "R9 high untouched");
    rd(4, 8'h00, "R9 written unmapped reads zero");

    @(pulse_ev); #1;
    push_len(act + 8, "R9 length unchanged");
    wr(3, 8'h01);
    wr(2, 8'h00);
    rd(3, 8'h01, "R6 high nibble readback");
    act = 256;

    @(pulse_ev); #1;
    push_len(act + 8, "R6 12-bit value");
    wr(3, 8'hFF);
    rd(3, 8'h0F, "R3 reserved masked");
    wr(2, 8'hFF);
    act = 4095;

    @(pulse_ev); #1;
    push_len(act + 8, "R7 both fields together");
    wr(2, 8'h01);
    wr(3, 8'h00);
    act = 1;

    @(pulse_ev); #1;
    push_len(act + 8, "R5 minimum odd");

    @(pulse_ev); #1;
    push_len(act + 8, "R8 repeated short line");

    @(pulse_ev);
    repeat (2) @(negedge clk);
    check(len_q.size() == 0, "R4 pending lines", len_q.size(), 0);
    finish_run();
  end
endmodule